// File: doc/BRIEF.md
# Shared-Indication Forcing Wrapper for a Mixed MSI/MESI Snooping Pair

This block sits between a snooping bus and two caches that speak different coherence protocols. One cache follows a three-state protocol (Invalid, Shared, Modified). The other can also take lines Exclusive. Without help, the four-state cache could take a line Exclusive and later modify it silently, leaving a stale Shared copy in its neighbour. The wrapper stops this by presenting the shared indication as asserted to the four-state cache on every read that cache issues. So that cache always fills lines as Shared, never reaches Exclusive, and the pair runs one common three-state protocol.

Requests arrive on a valid/ready channel: the requesting cache, read or write, and the line index. For each accepted request the wrapper reports the bus command that the access costs. When the other cache holds the line Modified, the wrapper first spends one cycle on a write-back and holds off the request. The wrapper keeps a per-line state tracker for each cache. The trackers follow the common protocol and can be read through a probe port, so whole access sequences can be checked from outside. The tracker of the four-state cache fills from the shared indication the wrapper actually drives, so a fault in the forcing shows up as an Exclusive line.

Back-pressure rule: a request is taken on a rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester keeps `req_valid` high and the request fields unchanged. `req_ready` goes low only in the write-back cycle.

Top module: `coh_shared_wrap`

## Requirements
- R1: While a read request from the four-state cache (`req_master`=1, `req_write`=0) is presented, `mesi_shared_out` is 1 whatever `bus_shared_in` is.
- R2: `msi_shared_out` always equals `bus_shared_in`. `mesi_shared_out` equals `bus_shared_in` whenever no four-state read is presented.
- R3: The probe outputs encode line states as I=0, S=1, E=2, M=3. After reset every line of both trackers reads 0, and no tracker line ever reads 2.
- R4: An accepted read that misses (requester in I) leaves the requester in S and reports `bus_cmd`=1 (read). A read that hits (S or M) leaves the state alone and reports `bus_cmd`=0 (none).
- R5: An accepted write leaves the requester in M and the other cache in I. It reports `bus_cmd`=3 (upgrade/invalidate) from S, 2 (read-for-ownership) from I, and 0 from M.
- R6: If the other cache holds the requested line in M, the first cycle of the request shows `req_ready`=0, `wb_valid`=1, `wb_line` = the request line and `wb_owner` = the other cache. The next cycle shows `req_ready`=1 and `wb_valid`=0.
- R7: A read that snoops a Modified line in the other cache leaves both caches in S after acceptance.
- R8: At no time is a line M in one tracker while it is valid (not I) in the other.
- R9: Outside the write-back cycle `req_ready` is 1, `bus_cmd` is non-zero only in a cycle where a request is accepted, and a pending request stays presented until it is taken.
- R10: On one line, the sequence three-state read, four-state read, four-state write, three-state read ends with both caches in S and reports one write-back, owned by the four-state cache, before the last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be taken this cycle |
| req_master | input | 1 | Requesting cache: 0 three-state, 1 four-state |
| req_write | input | 1 | 1 write, 0 read |
| req_line | input | LINE_W | Line index |
| bus_shared_in | input | 1 | Real shared response from the bus |
| mesi_shared_out | output | 1 | Shared indication seen by the four-state cache |
| msi_shared_out | output | 1 | Shared indication seen by the three-state cache |
| bus_cmd | output | 2 | Bus command of the accepted request: 0 none, 1 read, 2 read-for-ownership, 3 upgrade |
| wb_valid | output | 1 | Write-back of a Modified line in progress |
| wb_owner | output | 1 | Cache that writes back (same encoding as req_master) |
| wb_line | output | LINE_W | Line being written back |
| probe_line | input | LINE_W | Line to read out of the trackers |
| probe_msi_state | output | 2 | State of the probed line in the three-state cache |
| probe_mesi_state | output | 2 | State of the probed line in the four-state cache |

## Verification
The bench aims at reads from the four-state cache with the real shared response low. A design that passed that response through would let the tracker fill Exclusive, and the probe would read 2. It also aims at requests that meet a Modified line in the other cache. A design that skipped the write-back stall would show `req_ready` high with no `wb_valid`, and one that forgot to demote the owner would leave two valid copies with one Modified. Writes from S, I and M are mixed so that a wrong upgrade, read-for-ownership or silent-hit choice shows on `bus_cmd`. The four-step sequence from the requirements is also run directly.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_READ = 2'd1,
    CMD_RFO  = 2'd2,
    CMD_UPGR = 2'd3
  } bus_cmd_t;

  localparam logic MST_MSI  = 1'b0;
  localparam logic MST_MESI = 1'b1;

  // State of the requesting cache after its own access is taken.
  function automatic line_st_t own_next(line_st_t cur, logic wr,
                                        logic shared_seen, logic can_excl);
    if (wr) return ST_M;
    if (cur == ST_I) return (can_excl && !shared_seen) ? ST_E : ST_S;
    return cur;
  endfunction

  // State of the snooping cache after the other cache's access is taken.
  function automatic line_st_t snoop_next(line_st_t cur, logic wr);
    if (wr) return ST_I;
    if (cur == ST_M || cur == ST_E) return ST_S;
    return cur;
  endfunction

  // Bus command an access costs, given the requester's current state.
  function automatic bus_cmd_t cmd_for(line_st_t cur, logic wr);
    if (wr) begin
      if (cur == ST_M) return CMD_NONE;
      if (cur == ST_I) return CMD_RFO;
      return CMD_UPGR;
    end
    return (cur == ST_I) ? CMD_READ : CMD_NONE;
  endfunction

endpackage

// File: rtl/coh_line_tracker.sv
module coh_line_tracker
  import coh_pkg::*;
#(
  parameter int LINE_W  = 3,
  parameter bit IS_MESI = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd_en,
  input  logic [LINE_W-1:0]      upd_line,
  input  logic                   upd_own,
  input  logic                   upd_wr,
  input  logic                   shared_seen,
  output line_st_t               st_at_req,
  output logic [2*(1<<LINE_W)-1:0] st_flat
);
  localparam int LINES = 1 << LINE_W;

  line_st_t st_q [LINES];
  line_st_t st_new;

  assign st_at_req = st_q[upd_line];

  always_comb begin
    if (upd_own) st_new = own_next(st_q[upd_line], upd_wr, shared_seen, IS_MESI);
    else         st_new = snoop_next(st_q[upd_line], upd_wr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else if (upd_en) begin
      st_q[upd_line] <= st_new;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign st_flat[2*g +: 2] = st_q[g];

    // R3: the common protocol never holds a line Exclusive
    assert_no_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[g] != ST_E);
  end

endmodule

// File: rtl/coh_shared_ctrl.sv
module coh_shared_ctrl
  import coh_pkg::*;
#(
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_master,
  input  logic              req_write,
  input  logic [LINE_W-1:0] req_line,
  input  logic              bus_shared_in,
  input  line_st_t          msi_cur,
  input  line_st_t          mesi_cur,
  output logic              req_ready,
  output logic              accept,
  output logic              mesi_shared_out,
  output logic              msi_shared_out,
  output logic [1:0]        bus_cmd,
  output logic              wb_valid,
  output logic              wb_owner,
  output logic [LINE_W-1:0] wb_line
);
  typedef enum logic {PH_RUN, PH_WB} phase_t;

  phase_t   ph_q, ph_d;
  line_st_t own_st, oth_st;
  logic     conflict;
  logic     mesi_read;

  assign own_st    = (req_master == MST_MESI) ? mesi_cur : msi_cur;
  assign oth_st    = (req_master == MST_MESI) ? msi_cur  : mesi_cur;
  assign conflict  = req_valid && (oth_st == ST_M);
  assign mesi_read = req_valid && (req_master == MST_MESI) && !req_write;

  // Forcing toward the four-state cache; the three-state cache sees the bus.
  assign mesi_shared_out = bus_shared_in | mesi_read;
  assign msi_shared_out  = bus_shared_in;

  always_comb begin
    ph_d      = ph_q;
    req_ready = 1'b1;
    wb_valid  = 1'b0;
    if (ph_q == PH_RUN) begin
      if (conflict) begin
        req_ready = 1'b0;
        wb_valid  = 1'b1;
        ph_d      = PH_WB;
      end
    end else begin
      ph_d = PH_RUN;
    end
  end

  assign accept   = req_valid && req_ready;
  assign wb_owner = ~req_master;
  assign wb_line  = req_line;
  assign bus_cmd  = accept ? cmd_for(own_st, req_write) : CMD_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_RUN;
    else        ph_q <= ph_d;
  end

  // R1: a four-state read always sees the shared indication asserted
  assert_mesi_read_forced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_master && !req_write) |-> mesi_shared_out);

  // R2: the three-state cache sees the real response
  assert_msi_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    msi_shared_out == bus_shared_in);

  // R6: a write-back cycle holds the request off, the next cycle takes it
  assert_wb_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !req_ready);
  assert_wb_then_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> (req_ready && !wb_valid));

  // R9: bus commands appear only on accepted requests
  assert_cmd_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != CMD_NONE) |-> (req_valid && req_ready));

  // R9: a stalled request stays presented
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_line)
                                   && $stable(req_master) && $stable(req_write)));

endmodule

// File: rtl/coh_shared_wrap.sv
module coh_shared_wrap
  import coh_pkg::*;
#(
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_master,
  input  logic              req_write,
  input  logic [LINE_W-1:0] req_line,
  input  logic              bus_shared_in,
  output logic              mesi_shared_out,
  output logic              msi_shared_out,
  output logic [1:0]        bus_cmd,
  output logic              wb_valid,
  output logic              wb_owner,
  output logic [LINE_W-1:0] wb_line,
  input  logic [LINE_W-1:0] probe_line,
  output logic [1:0]        probe_msi_state,
  output logic [1:0]        probe_mesi_state
);
  localparam int LINES = 1 << LINE_W;

  logic                 accept;
  line_st_t             msi_cur, mesi_cur;
  logic [2*LINES-1:0]   msi_flat, mesi_flat;

  coh_shared_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk, .rst_n, .req_valid, .req_master, .req_write, .req_line,
    .bus_shared_in, .msi_cur, .mesi_cur, .req_ready, .accept,
    .mesi_shared_out, .msi_shared_out, .bus_cmd, .wb_valid, .wb_owner, .wb_line
  );

  coh_line_tracker #(.LINE_W(LINE_W), .IS_MESI(1'b0)) u_trk_msi (
    .clk, .rst_n, .upd_en(accept), .upd_line(req_line),
    .upd_own(req_master == MST_MSI), .upd_wr(req_write),
    .shared_seen(msi_shared_out), .st_at_req(msi_cur), .st_flat(msi_flat)
  );

  coh_line_tracker #(.LINE_W(LINE_W), .IS_MESI(1'b1)) u_trk_mesi (
    .clk, .rst_n, .upd_en(accept), .upd_line(req_line),
    .upd_own(req_master == MST_MESI), .upd_wr(req_write),
    .shared_seen(mesi_shared_out), .st_at_req(mesi_cur), .st_flat(mesi_flat)
  );

  assign probe_msi_state  = msi_flat[2*probe_line +: 2];
  assign probe_mesi_state = mesi_flat[2*probe_line +: 2];

  for (genvar g = 0; g < LINES; g++) begin : g_own
    // R8: a Modified copy excludes any other valid copy
    assert_single_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !((msi_flat[2*g +: 2] == 2'(ST_M) && mesi_flat[2*g +: 2] != 2'(ST_I)) ||
        (mesi_flat[2*g +: 2] == 2'(ST_M) && msi_flat[2*g +: 2] != 2'(ST_I))));
  end

endmodule

// File: tb/test_coh_shared_wrap.sv
`timescale 1ns/1ps
module test_coh_shared_wrap;
  localparam int LINE_W = 3;
  localparam int LINES  = 1 << LINE_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_master = 0, req_write = 0, bus_shared_in = 0;
  logic [LINE_W-1:0] req_line = '0, probe_line = '0;
  logic req_ready, mesi_shared_out, msi_shared_out, wb_valid, wb_owner;
  logic [1:0] bus_cmd, probe_msi_state, probe_mesi_state;
  logic [LINE_W-1:0] wb_line;

  int checks = 0, errors = 0;
  int ma [LINES];
  int mb [LINES];
  int wb_seen;

  always #2 clk = ~clk;

  coh_shared_wrap #(.LINE_W(LINE_W)) i_coh_shared_wrap (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int exp_cmd(int own, bit wr);
    if (wr) return (own == 3) ? 0 : (own == 0) ? 2 : 3;
    return (own == 0) ? 1 : 0;
  endfunction

  task automatic check_line(input int ln);
    probe_line = LINE_W'(ln);
    #1;
    chk(int'(probe_msi_state)  == ma[ln], "R4/R5/R7 msi state",  probe_msi_state,  ma[ln]);
    chk(int'(probe_mesi_state) == mb[ln], "R3/R4/R5/R7 mesi state", probe_mesi_state, mb[ln]);
  endtask

  task automatic run_op(input bit m, input bit w, input int ln, input bit sh);
    int own, oth;
    @(negedge clk);
    req_valid = 1; req_master = m; req_write = w;
    req_line = LINE_W'(ln); bus_shared_in = sh;
    #1;
    own = m ? mb[ln] : ma[ln];
    oth = m ? ma[ln] : mb[ln];
    if (oth == 3) begin
      chk(wb_valid && !req_ready && wb_line == LINE_W'(ln) && wb_owner == !m,
          "R6 writeback stall", {wb_valid, req_ready}, 2);
      wb_seen++;
      @(negedge clk); #1;
      chk(req_ready && !wb_valid, "R6 take after writeback", {wb_valid, req_ready}, 1);
    end else begin
      chk(req_ready && !wb_valid, "R9 ready outside writeback", {wb_valid, req_ready}, 1);
    end
    chk(int'(bus_cmd) == exp_cmd(own, w), "R4/R5 bus_cmd", bus_cmd, exp_cmd(own, w));
    if (m && !w) chk(mesi_shared_out == 1'b1, "R1 forced shared", mesi_shared_out, 1);
    else         chk(mesi_shared_out == sh, "R2 mesi passthru", mesi_shared_out, sh);
    chk(msi_shared_out == sh, "R2 msi passthru", msi_shared_out, sh);
    @(posedge clk); #1;
    req_valid = 0;
    chk(bus_cmd == 2'd0, "R9 no cmd when idle", bus_cmd, 0);
    if (w) begin
      if (m) begin mb[ln] = 3; ma[ln] = 0; end
      else   begin ma[ln] = 3; mb[ln] = 0; end
    end else begin
      if (m) begin if (mb[ln] == 0) mb[ln] = 1; if (ma[ln] == 3) ma[ln] = 1; end
      else   begin if (ma[ln] == 0) ma[ln] = 1; if (mb[ln] == 3) mb[ln] = 1; end
    end
    check_line(ln);
  endtask

  task automatic check_all_r8;
    for (int i = 0; i < LINES; i++) begin
      probe_line = LINE_W'(i);
      #1;
      chk(!((probe_msi_state == 3 && probe_mesi_state != 0) ||
            (probe_mesi_state == 3 && probe_msi_state != 0)) && probe_mesi_state != 2,
          "R8/R3 single owner no E", {probe_msi_state, probe_mesi_state}, 0);
    end
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    for (int i = 0; i < LINES; i++) begin ma[i] = 0; mb[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R3: reset state
    for (int i = 0; i < LINES; i++) check_line(i);
    chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);

    // R10: directed sequence on line 5
    wb_seen = 0;
    run_op(0, 0, 5, 0);
    run_op(1, 0, 5, 0);   // R1 with real shared low: must fill S
    chk(mb[5] == 1 && int'(probe_mesi_state) == 1, "R10 mesi read fills S", probe_mesi_state, 1);
    run_op(1, 1, 5, 0);   // upgrade from S
    run_op(0, 0, 5, 1);   // snoop hit on M, writeback by four-state cache
    chk(wb_seen == 1 && int'(probe_msi_state) == 1 && int'(probe_mesi_state) == 1,
        "R10 end both shared", {probe_msi_state, probe_mesi_state}, 5);

    // R5: write from I and write hit on M, R7: four-state read of MSI M line
    run_op(0, 1, 2, 0);
    run_op(0, 1, 2, 1);
    run_op(1, 0, 2, 0);
    run_op(1, 1, 3, 1);
    run_op(0, 1, 3, 0);
    check_all_r8();

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom_range(0, 3));
      run_op(r[0], r[1] & ($urandom_range(0, 2) != 0), int'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)));
      if (n % 50 == 0) check_all_r8();
    end
    check_all_r8();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule